// File: doc/BRIEF.md
# Read-Out Request Sequencer with Debug Stop

This controller decides when a buffered event is handed to the downstream network. It watches the status word of an event queue. When that word says the queue is not empty, it raises a one-cycle request. It then waits until the network reports busy, and after that waits until the network reports idle again. At that point one read-out is complete and is counted.

For debugging, a read-out limit can be loaded. Once the number of completed read-outs reaches that limit, the next time data is waiting the sequencer parks in a halt state instead of sending another request. It stays there until a new limit is written or reset is applied. The all-ones limit value disables the stop.

The current state is presented as a one-hot word so that a register read can show it directly. Storing the queue and formatting the data belong to other blocks.

Top module: `ro_request_ctrl`

## Requirements
- R1: `state_onehot_o` always has exactly one bit set, with this encoding: bit 0 idle, bit 1 send-request, bit 2 wait-for-busy, bit 3 wait-for-idle, bit 4 halted at limit.
- R2: While `rst_ni` is low, and on the first cycle after it, the state is idle and `req_o` is low. Reset also clears the read-out count and sets the limit to 0xFFFF (no limit).
- R3: In idle, bit 30 of `queue_status_i` (1 = queue empty) alone decides whether a read-out may start. With bit 30 set, the state stays idle. The word count in bits 15:0 and the full flag in bit 31 have no effect. With bit 30 clear and the limit not reached, the state is send-request in the next cycle.
- R4: `req_o` is high exactly in the send-request state, and only for one cycle. Wait-for-busy follows unconditionally.
- R5: Wait-for-busy holds while `net_busy_i` is low. The cycle after `net_busy_i` is seen high, the state is wait-for-idle.
- R6: Wait-for-idle holds while `net_busy_i` is high. The cycle after it is seen low, the state is idle again and the read-out count increases by one.
- R7: A one-cycle `limit_wr_i` loads `limit_i` and clears the read-out count in any state, including in the middle of a read-out, which then continues. If the limit L is not 0xFFFF and the count is at least L, idle with data waiting goes to the halt state instead of send-request. L = 0 therefore halts before the first read-out.
- R8: With the limit at 0xFFFF, the halt state is never entered, however many read-outs complete.
- R9: The halt state ignores the queue status and `net_busy_i` and never raises `req_o`. It is left only through reset, or for idle on the cycle after a `limit_wr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| queue_status_i | input | 32 | Queue status word: bits 15:0 word count, bit 30 empty, bit 31 full |
| net_busy_i | input | 1 | Network busy indication |
| limit_wr_i | input | 1 | Strobe that loads a new read-out limit |
| limit_i | input | 16 | Read-out limit value, 0xFFFF = unlimited |
| req_o | output | 1 | One-cycle read-out request |
| state_onehot_o | output | 5 | Current state, one-hot |

## Verification
A wrong state register or transition shows up on `state_onehot_o` on the first clock after the faulty edge. A lost or doubled request shows on `req_o` in that same cycle. Errors in the limit counter stay hidden until the next idle cycle with data waiting. At that point the block shows send-request where halt was due, or the reverse, one cycle after the decision.

The reference model follows the state and count on every clock. For this reason, a miscounted read-out is caught at the first decision that depends on it, and never later.

// File: rtl/ro_ctrl_pkg.sv
package ro_ctrl_pkg;

   localparam int NUM_STATES = 5;
   localparam int STATE_W    = 3;

   // Encoding value equals the one-hot bit index presented to software.
   typedef enum logic [STATE_W-1:0] {
      ST_IDLE  = 3'd0,
      ST_SEND  = 3'd1,
      ST_WBUSY = 3'd2,
      ST_WIDLE = 3'd3,
      ST_HALT  = 3'd4
   } ro_state_e;

endpackage

// File: rtl/ro_qstat_decode.sv
module ro_qstat_decode #(
   parameter int QSTAT_W   = 32,
   parameter int EMPTY_BIT = 30
) (
   input  logic [QSTAT_W-1:0] status_i,
   output logic               has_data_o
);
   generate
      if (EMPTY_BIT >= QSTAT_W) begin : g_bad_empty_bit
         $error("EMPTY_BIT outside the status word");
      end
   endgenerate

   // Only the empty flag steers the sequencer; count and full are informative.
   logic unused_status_bits;
   assign unused_status_bits = ^status_i;

   assign has_data_o = ~status_i[EMPTY_BIT];
endmodule

// File: rtl/ro_limit_tracker.sv
module ro_limit_tracker #(
   parameter int LIMIT_W   = 16,
   parameter bit SAT_COUNT = 1'b1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               done_i,
   input  logic               wr_i,
   input  logic [LIMIT_W-1:0] limit_i,
   output logic               reached_o
);
   localparam logic [LIMIT_W-1:0] NO_LIMIT = {LIMIT_W{1'b1}};
   localparam logic [LIMIT_W-1:0] CNT_ONE  = LIMIT_W'(1);

   generate
      if (LIMIT_W < 2) begin : g_bad_limit_w
         $error("LIMIT_W must be at least 2");
      end
   endgenerate

   logic [LIMIT_W-1:0] limit_q;
   logic [LIMIT_W-1:0] count_q;
   logic [LIMIT_W-1:0] count_inc;

   generate
      if (SAT_COUNT) begin : g_sat
         assign count_inc = (count_q == NO_LIMIT) ? count_q : count_q + CNT_ONE;
      end else begin : g_wrap
         assign count_inc = count_q + CNT_ONE;
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         limit_q <= NO_LIMIT;
         count_q <= '0;
      end else if (wr_i) begin
         limit_q <= limit_i;
         count_q <= '0;
      end else if (done_i) begin
         count_q <= count_inc;
      end
   end

   assign reached_o = (limit_q != NO_LIMIT) && (count_q >= limit_q);
endmodule

// File: rtl/ro_seq_fsm.sv
module ro_seq_fsm
   import ro_ctrl_pkg::*;
(
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  has_data_i,
   input  logic                  busy_i,
   input  logic                  reached_i,
   input  logic                  wr_i,
   output logic                  req_o,
   output logic                  done_o,
   output logic [NUM_STATES-1:0] onehot_o
);
   ro_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (has_data_i) state_d = reached_i ? ST_HALT : ST_SEND;
         ST_SEND:  state_d = ST_WBUSY;
         ST_WBUSY: if (busy_i) state_d = ST_WIDLE;
         ST_WIDLE: if (!busy_i) state_d = ST_IDLE;
         ST_HALT:  if (wr_i) state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) state_q <= ST_IDLE;
      else         state_q <= state_d;
   end

   assign req_o  = (state_q == ST_SEND);
   assign done_o = (state_q == ST_WIDLE) && !busy_i;

   for (genvar i = 0; i < NUM_STATES; i++) begin : g_oh
      assign onehot_o[i] = (state_q == ro_state_e'(STATE_W'(i)));
   end
endmodule

// File: rtl/ro_request_ctrl.sv
module ro_request_ctrl
   import ro_ctrl_pkg::*;
#(
   parameter int QSTAT_W   = 32,
   parameter int EMPTY_BIT = 30,
   parameter int LIMIT_W   = 16,
   parameter bit SAT_COUNT = 1'b1
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic [QSTAT_W-1:0]    queue_status_i,
   input  logic                  net_busy_i,
   input  logic                  limit_wr_i,
   input  logic [LIMIT_W-1:0]    limit_i,
   output logic                  req_o,
   output logic [NUM_STATES-1:0] state_onehot_o
);
   logic has_data;
   logic reached;
   logic done;

   ro_qstat_decode #(.QSTAT_W(QSTAT_W), .EMPTY_BIT(EMPTY_BIT)) u_qdec (
      .status_i   (queue_status_i),
      .has_data_o (has_data)
   );

   ro_limit_tracker #(.LIMIT_W(LIMIT_W), .SAT_COUNT(SAT_COUNT)) u_lim (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .done_i    (done),
      .wr_i      (limit_wr_i),
      .limit_i   (limit_i),
      .reached_o (reached)
   );

   ro_seq_fsm u_fsm (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .has_data_i (has_data),
      .busy_i     (net_busy_i),
      .reached_i  (reached),
      .wr_i       (limit_wr_i),
      .req_o      (req_o),
      .done_o     (done),
      .onehot_o   (state_onehot_o)
   );
endmodule

// File: rtl/ro_request_ctrl_chk.sv
module ro_request_ctrl_chk #(
   parameter int QSTAT_W   = 32,
   parameter int EMPTY_BIT = 30,
   parameter int LIMIT_W   = 16
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic [QSTAT_W-1:0] queue_status_i,
   input logic               net_busy_i,
   input logic               limit_wr_i,
   input logic [LIMIT_W-1:0] limit_i,
   input logic               req_o,
   input logic [4:0]         state_onehot_o
);
   logic unused_limit;
   assign unused_limit = ^limit_i;

   a_r1_single_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(state_onehot_o) == 1);

   a_r2_reset_idle: assert property (@(posedge clk_i)
      !rst_ni |=> state_onehot_o[0] && !req_o);

   a_r3_empty_stays_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      state_onehot_o[0] && queue_status_i[EMPTY_BIT] |=> state_onehot_o[0]);

   a_r4_req_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_o |=> !req_o && state_onehot_o[2]);

   a_r5_busy_seen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      state_onehot_o[2] && net_busy_i |=> state_onehot_o[3]);

   a_r6_idle_seen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      state_onehot_o[3] && !net_busy_i |=> state_onehot_o[0]);

   a_r9_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      state_onehot_o[4] && !limit_wr_i |=> state_onehot_o[4] && !req_o);

   a_r9_halt_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
      state_onehot_o[4] && limit_wr_i |=> state_onehot_o[0]);
endmodule

bind ro_request_ctrl ro_request_ctrl_chk #(
   .QSTAT_W(QSTAT_W), .EMPTY_BIT(EMPTY_BIT), .LIMIT_W(LIMIT_W)
) u_chk (
   .clk_i          (clk_i),
   .rst_ni         (rst_ni),
   .queue_status_i (queue_status_i),
   .net_busy_i     (net_busy_i),
   .limit_wr_i     (limit_wr_i),
   .limit_i        (limit_i),
   .req_o          (req_o),
   .state_onehot_o (state_onehot_o)
);

// File: tb/tb_ro_request_ctrl.sv
module tb_ro_request_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] qstat = 32'h4000_0000;
   logic        busy = 1'b0;
   logic        wr = 1'b0;
   logic [15:0] lim = 16'h0;
   logic        req;
   logic [4:0]  oh;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   bit done_flag = 1'b0;

   // behavioural reference
   int m_st  = 0;
   int m_cnt = 0;
   int m_lim = 65535;

   always #5 clk = ~clk;

   ro_request_ctrl dut (
      .clk_i(clk), .rst_ni(rst_n), .queue_status_i(qstat), .net_busy_i(busy),
      .limit_wr_i(wr), .limit_i(lim), .req_o(req), .state_onehot_o(oh)
   );

   always @(posedge clk) begin
      int nst, ncnt, nlim;
      bit reached;
      if (!rst_n) begin
         m_st = 0; m_cnt = 0; m_lim = 65535;
      end else begin
         nst = m_st; ncnt = m_cnt; nlim = m_lim;
         reached = (m_lim != 65535) && (m_cnt >= m_lim);
         case (m_st)
            0: if (!qstat[30]) nst = reached ? 4 : 1;
            1: nst = 2;
            2: if (busy) nst = 3;
            3: if (!busy) begin
                  nst = 0;
                  ncnt = (m_cnt == 65535) ? m_cnt : m_cnt + 1;
               end
            default: if (wr) nst = 0;
         endcase
         if (wr) begin nlim = int'(lim); ncnt = 0; end
         m_st = nst; m_cnt = ncnt; m_lim = nlim;
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done_flag) begin
         failures++;
         $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic check(input string tag);
      logic [4:0] exp_oh;
      logic       exp_req;
      exp_oh  = 5'b1 << m_st;
      exp_req = (m_st == 1);
      checks++;
      if (oh !== exp_oh || req !== exp_req) begin
         failures++;
         $display("FAIL %s: actual oh=%b req=%b expected oh=%b req=%b",
                  tag, oh, req, exp_oh, exp_req);
      end
   endtask

   // empty flag in bit 30; junk count and full bits must not matter
   task automatic drive(input bit emp, input bit b, input bit w,
                        input logic [15:0] l, input int n, input string tag);
      repeat (n) begin
         @(negedge clk);
         check(tag);
         qstat = 32'h8000_0007 | (emp ? 32'h4000_0000 : 32'h0);
         busy  = b;
         wr    = w;
         lim   = l;
      end
   endtask

   task automatic readout(input string tag);
      drive(0, 0, 0, 0, 2, tag);
      drive(1, 1, 0, 0, 2, tag);
      drive(1, 0, 0, 0, 2, tag);
   endtask

   initial begin
      drive(1, 0, 0, 0, 3, "R2");
      rst_n = 1'b1;
      drive(1, 0, 0, 0, 5, "R3");
      drive(0, 0, 0, 0, 1, "R3");
      drive(0, 0, 0, 0, 3, "R4");
      drive(0, 1, 0, 0, 1, "R5");
      drive(0, 1, 0, 0, 3, "R6");
      drive(1, 0, 0, 0, 2, "R6");
      drive(1, 0, 1, 16'd2, 1, "R7");
      readout("R7");
      readout("R7");
      drive(0, 0, 0, 0, 3, "R7");
      drive(0, 1, 0, 0, 3, "R9");
      drive(1, 0, 0, 0, 2, "R9");
      drive(0, 0, 1, 16'hFFFF, 1, "R9");
      for (int i = 0; i < 6; i++) readout("R8");
      drive(1, 0, 1, 16'd0, 1, "R7");
      drive(0, 0, 0, 0, 3, "R7");
      drive(1, 0, 1, 16'd1, 1, "R9");
      drive(0, 0, 0, 0, 2, "R7");
      drive(1, 1, 0, 0, 2, "R7");
      drive(1, 1, 1, 16'd1, 1, "R7");
      drive(1, 0, 0, 0, 2, "R7");
      readout("R7");
      drive(0, 0, 0, 0, 3, "R7");
      rst_n = 1'b0;
      drive(0, 0, 0, 0, 2, "R2");
      rst_n = 1'b1;
      for (int i = 0; i < 3; i++) readout("R2");
      drive(1, 0, 0, 0, 2, "R1");
      done_flag = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule